// File: doc/BRIEF.md
# Cycle-Qualified Protection Filter

This block sits between the analog comparators of an off-line switching converter and its start-up sequencer. It turns three noisy protection inputs into one clean latched fault. Output over-voltage is read only in a short strobe window that opens a fixed delay after the power switch turns off. At that point the auxiliary winding voltage has settled. Second-level over-current is read at any time during an oscillator cycle. Each source must persist over consecutive oscillator cycles before it counts, and any clean cycle discards the evidence gathered so far.

Feedback overload is taken at once when the overload comparator and the linear-range comparator are both high. The block also drives a pulse-skip signal for light-load burst operation. This signal is built from two feedback comparator bits that form a hysteresis band. The latched fault is held until the supply under-voltage signal clears it. A 3-bit cause vector records which sources set the fault.

Top module: `prot_filter_top`

## Requirements
- R1: After reset, `fault`, `fault_cause` and `pulse_skip` are all zero.
- R2: `ovp_cmp` is taken into account only while the strobe window is open. With k counting the clocks since the first clock edge that sees `gate_on` low after it was high, the window is open for k from STROBE_DLY+1 to STROBE_DLY+STROBE_WID. It closes whenever `gate_on` is high. A high `ovp_cmp` outside the window has no effect on `fault`.
- R3: If an over-voltage hit falls inside the window in OVP_CYCLES consecutive oscillator cycles (default 4), `fault` rises. It becomes visible on the clock after `cycle_end` closes the last of those cycles. One cycle fewer does not raise it.
- R4: Any oscillator cycle that ends without an over-voltage hit sets the over-voltage run count back to zero.
- R5: A high `ocp_cmp` at any clock in a cycle is a trip for that cycle. The first trip is a warning only. A trip in the next cycle as well (OCP_CYCLES = 2) raises `fault`. A clean cycle after a warning returns to idle, so trip, clean, trip does not raise `fault`.
- R6: Once set, `fault` and `fault_cause` hold until `uvlo` is high at a clock edge. That edge clears them and also clears both run counts. `uvlo` takes priority over any new fault.
- R7: `fault_cause` is captured when `fault` rises and then holds. Bit 0 marks over-voltage, bit 1 marks second-level over-current and bit 2 marks overload. More than one bit is set when sources qualify on the same edge.
- R8: `pulse_skip` rises on the clock after `fb_below_hys` is high. It falls on the clock after `fb_above_bm` is high while `fb_below_hys` is low. With both low it holds its value.
- R9: When `fb_at_olp` and `fb_above_lin` are both high at a clock edge, `fault` is set on that edge. `fb_at_olp` alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_on | input | 1 | Power switch gate command, high while on |
| cycle_end | input | 1 | One-clock pulse at the end of each oscillator cycle |
| ovp_cmp | input | 1 | Output over-voltage comparator |
| ocp_cmp | input | 1 | Second-level over-current comparator |
| fb_below_hys | input | 1 | Feedback below burst threshold minus hysteresis |
| fb_above_bm | input | 1 | Feedback above burst threshold |
| fb_above_lin | input | 1 | Feedback above linear-range limit |
| fb_at_olp | input | 1 | Feedback at overload threshold |
| uvlo | input | 1 | Supply under-voltage, clears the latched fault |
| fault | output | 1 | Latched fault to the sequencer |
| fault_cause | output | 3 | Latched cause: bit0 over-voltage, bit1 over-current, bit2 overload |
| pulse_skip | output | 1 | Burst-mode skip request |

## Verification
The assertions assume that `cycle_end` is a single-clock pulse. They also assume that the two burst comparator bits are never high together, since the lower threshold sits below the upper one. The stimulus builds every oscillator cycle in the same order: on-time, off-time, then one `cycle_end` pulse. It never raises both burst bits in the same clock. Over-voltage pulses are placed in clocks known to fall inside or outside the strobe window, so the window boundaries on both sides are exercised.

// File: rtl/prot_filt_pkg.sv
`timescale 1ns/1ps
package prot_filt_pkg;
    localparam int CAUSE_W   = 3;
    localparam int CAUSE_OVP = 0;
    localparam int CAUSE_OCP = 1;
    localparam int CAUSE_OLP = 2;

    typedef struct packed {
        logic               fault;
        logic [CAUSE_W-1:0] cause;
    } fault_latch_t;
endpackage

// File: rtl/prot_strobe_gen.sv
`timescale 1ns/1ps
module prot_strobe_gen #(
    parameter int DLY = 100,
    parameter int WID = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on,
    output logic strobe
);
    localparam int END_CNT = DLY + WID;
    localparam int CW      = $clog2(END_CNT + 2);
    localparam logic [CW-1:0] DLY_V = CW'(DLY);
    localparam logic [CW-1:0] END_V = CW'(END_CNT);

    typedef struct packed {
        logic          gate;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.gate = gate_on;
        if (gate_on) begin
            st_d.cnt = '0;
        end else if (st_q.gate) begin
            st_d.cnt = CW'(1);
        end else if (st_q.cnt != '0 && st_q.cnt <= END_V) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = (st_q.cnt > DLY_V) && (st_q.cnt <= END_V);

    // R2
    strobe_closed_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_on |=> !strobe);
endmodule

// File: rtl/prot_cycle_qual.sv
`timescale 1ns/1ps
module prot_cycle_qual #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cycle_end,
    input  logic sample_en,
    input  logic sample,
    output logic qualified
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] N_V = CW'(N);

    typedef struct packed {
        logic          hit;
        logic [CW-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic hit_now;

    always_comb begin
        hit_now = st_q.hit | (sample_en & sample);
        st_d    = st_q;
        if (clr) begin
            st_d = '0;
        end else if (cycle_end) begin
            st_d.hit = 1'b0;
            if (!hit_now)          st_d.cnt = '0;
            else if (st_q.cnt != N_V) st_d.cnt = st_q.cnt + CW'(1);
        end else begin
            st_d.hit = hit_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qualified = !clr && cycle_end && hit_now && (st_q.cnt == N_V - CW'(1));

    // R4
    clean_cycle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && !st_q.hit && !(sample_en && sample)) |=> (st_q.cnt == '0));
    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= N_V);
endmodule

// File: rtl/prot_burst_ctrl.sv
`timescale 1ns/1ps
module prot_burst_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_below_hys,
    input  logic fb_above_bm,
    output logic skip
);
    logic skip_d, skip_q;

    always_comb begin
        skip_d = skip_q;
        if (fb_below_hys)     skip_d = 1'b1;
        else if (fb_above_bm) skip_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) skip_q <= 1'b0;
        else        skip_q <= skip_d;
    end

    assign skip = skip_q;

    // R8
    skip_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_below_hys |=> skip);
    // R8
    skip_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_above_bm && !fb_below_hys) |=> !skip);
    // R8
    skip_band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb_above_bm && !fb_below_hys) |=> $stable(skip));
endmodule

// File: rtl/prot_filter_top.sv
`timescale 1ns/1ps
module prot_filter_top
    import prot_filt_pkg::*;
#(
    parameter int STROBE_DLY = 100,
    parameter int STROBE_WID = 25,
    parameter int OVP_CYCLES = 4,
    parameter int OCP_CYCLES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate_on,
    input  logic               cycle_end,
    input  logic               ovp_cmp,
    input  logic               ocp_cmp,
    input  logic               fb_below_hys,
    input  logic               fb_above_bm,
    input  logic               fb_above_lin,
    input  logic               fb_at_olp,
    input  logic               uvlo,
    output logic               fault,
    output logic [CAUSE_W-1:0] fault_cause,
    output logic               pulse_skip
);
    logic               strobe;
    logic               ovp_qual, ocp_qual;
    logic [CAUSE_W-1:0] src;
    fault_latch_t       lat_d, lat_q;

    prot_strobe_gen #(.DLY(STROBE_DLY), .WID(STROBE_WID)) u_strobe (
        .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .strobe(strobe));

    prot_cycle_qual #(.N(OVP_CYCLES)) u_ovp_qual (
        .clk(clk), .rst_n(rst_n), .clr(uvlo), .cycle_end(cycle_end),
        .sample_en(strobe), .sample(ovp_cmp), .qualified(ovp_qual));

    prot_cycle_qual #(.N(OCP_CYCLES)) u_ocp_qual (
        .clk(clk), .rst_n(rst_n), .clr(uvlo), .cycle_end(cycle_end),
        .sample_en(1'b1), .sample(ocp_cmp), .qualified(ocp_qual));

    prot_burst_ctrl u_burst (
        .clk(clk), .rst_n(rst_n), .fb_below_hys(fb_below_hys),
        .fb_above_bm(fb_above_bm), .skip(pulse_skip));

    always_comb begin
        src            = '0;
        src[CAUSE_OVP] = ovp_qual;
        src[CAUSE_OCP] = ocp_qual;
        src[CAUSE_OLP] = fb_at_olp & fb_above_lin;
    end

    always_comb begin
        lat_d = lat_q;
        if (uvlo) begin
            lat_d = '0;
        end else if (!lat_q.fault && (src != '0)) begin
            lat_d.fault = 1'b1;
            lat_d.cause = src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign fault       = lat_q.fault;
    assign fault_cause = lat_q.cause;

    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !uvlo) |=> (fault && $stable(fault_cause)));
    // R6
    uvlo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (!fault && fault_cause == '0));
    // R7
    cause_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause != '0));
    // R9
    overload_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_at_olp && fb_above_lin && !uvlo) |=> fault);
endmodule

// File: tb/sim_prot_filter_top.sv
`timescale 1ns/1ps
module sim_prot_filter_top;
    localparam int DLY = 8;
    localparam int WID = 4;
    localparam int OVP_N = 4;
    localparam int OCP_N = 2;

    logic clk = 1'b0;
    logic rst_n, gate_on, cycle_end, ovp_cmp, ocp_cmp;
    logic fb_below_hys, fb_above_bm, fb_above_lin, fb_at_olp, uvlo;
    logic fault, pulse_skip;
    logic [2:0] fault_cause;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int m_ovp = 0;
    int m_ocp = 0;
    bit m_fault = 1'b0;
    logic [2:0] m_cause = 3'b000;

    always #10 clk = ~clk;

    prot_filter_top #(.STROBE_DLY(DLY), .STROBE_WID(WID),
                      .OVP_CYCLES(OVP_N), .OCP_CYCLES(OCP_N)) u0 (
        .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .cycle_end(cycle_end),
        .ovp_cmp(ovp_cmp), .ocp_cmp(ocp_cmp), .fb_below_hys(fb_below_hys),
        .fb_above_bm(fb_above_bm), .fb_above_lin(fb_above_lin),
        .fb_at_olp(fb_at_olp), .uvlo(uvlo), .fault(fault),
        .fault_cause(fault_cause), .pulse_skip(pulse_skip));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_cause(input int ovp_run, input int ocp_run);
        logic [2:0] c;
        c    = 3'b000;
        c[0] = (ovp_run >= OVP_N);
        c[1] = (ocp_run >= OCP_N);
        return c;
    endfunction

    // mode: 0 no pulse, 1 pulse inside window, 2 pulse before window, 3 pulse after window
    task automatic run_cycle(input int mode, input bit ocp, input string req);
        logic [2:0] c;
        @(negedge clk); gate_on = 1'b1; ocp_cmp = ocp;
        @(negedge clk); ocp_cmp = 1'b0;
        repeat (2) @(negedge clk);
        gate_on = 1'b0;
        for (int k = 1; k <= DLY + WID + 3; k++) begin
            @(negedge clk);
            ovp_cmp = (mode == 1 && k == DLY + 2) || (mode == 2 && k <= DLY) ||
                      (mode == 3 && k > DLY + WID);
        end
        @(negedge clk); ovp_cmp = 1'b0; cycle_end = 1'b1;
        @(negedge clk); cycle_end = 1'b0;
        m_ovp = (mode == 1) ? m_ovp + 1 : 0;
        m_ocp = ocp ? m_ocp + 1 : 0;
        c = exp_cause(m_ovp, m_ocp);
        if (!m_fault && c != 3'b000) begin
            m_fault = 1'b1;
            m_cause = c;
        end
        check(req, int'(fault), int'(m_fault));
        check(req, int'(fault_cause), int'(m_cause));
    endtask

    task automatic do_uvlo();
        @(negedge clk); uvlo = 1'b1;
        @(negedge clk); uvlo = 1'b0;
        m_ovp = 0; m_ocp = 0; m_fault = 1'b0; m_cause = 3'b000;
        check("R6 uvlo clears fault", int'(fault), 0);
        check("R6 uvlo clears cause", int'(fault_cause), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd2718);
        rst_n = 1'b0; gate_on = 1'b0; cycle_end = 1'b0; ovp_cmp = 1'b0; ocp_cmp = 1'b0;
        fb_below_hys = 1'b0; fb_above_bm = 1'b0; fb_above_lin = 1'b0; fb_at_olp = 1'b0;
        uvlo = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 fault after reset", int'(fault), 0);
        check("R1 cause after reset", int'(fault_cause), 0);
        check("R1 skip after reset", int'(pulse_skip), 0);

        // R3: three hits do not qualify, the fourth does
        for (int i = 0; i < 3; i++) run_cycle(1, 1'b0, "R3 below count");
        run_cycle(1, 1'b0, "R3 fourth hit");
        check("R3 ovp fault raised", int'(fault), 1);
        // R6: fault holds through clean cycles
        run_cycle(0, 1'b0, "R6 hold");
        run_cycle(0, 1'b0, "R6 hold");
        do_uvlo();

        // R4: a clean cycle restarts the run
        for (int i = 0; i < 3; i++) run_cycle(1, 1'b0, "R4 run");
        run_cycle(0, 1'b0, "R4 clean cycle");
        for (int i = 0; i < 3; i++) run_cycle(1, 1'b0, "R4 after restart");
        check("R4 no fault after broken run", int'(fault), 0);
        do_uvlo();

        // R2: pulses outside the strobe window are ignored
        for (int i = 0; i < 5; i++) run_cycle(2, 1'b0, "R2 early pulse");
        for (int i = 0; i < 5; i++) run_cycle(3, 1'b0, "R2 late pulse");
        check("R2 no fault from pulses outside window", int'(fault), 0);
        do_uvlo();

        // R5: warning, clean, trip stays clear; two in a row faults
        run_cycle(0, 1'b1, "R5 warning");
        run_cycle(0, 1'b0, "R5 back to idle");
        run_cycle(0, 1'b1, "R5 warning again");
        check("R5 no fault after single trip", int'(fault), 0);
        run_cycle(0, 1'b1, "R5 second trip");
        check("R7 cause ocp bit1", int'(fault_cause), 2);
        do_uvlo();

        // R7: both sources on the same edge
        for (int i = 0; i < 3; i++) run_cycle(1, 1'b0, "R7 prepare");
        run_cycle(1, 1'b1, "R7 ocp warn");
        do_uvlo();
        for (int i = 0; i < 3; i++) run_cycle(1, i == 2, "R7 prepare both");
        run_cycle(1, 1'b1, "R7 both qualify");
        check("R7 cause both bits", int'(fault_cause), 3);
        do_uvlo();

        // R9: overload needs both feedback bits
        @(negedge clk); fb_at_olp = 1'b1; fb_above_lin = 1'b0;
        @(negedge clk);
        check("R9 olp alone ignored", int'(fault), 0);
        fb_above_lin = 1'b1;
        @(negedge clk); fb_at_olp = 1'b0; fb_above_lin = 1'b0;
        check("R9 overload fault", int'(fault), 1);
        check("R7 cause olp bit2", int'(fault_cause), 4);
        m_fault = 1'b1; m_cause = 3'b100;
        do_uvlo();

        // R8: burst hysteresis band
        @(negedge clk); fb_below_hys = 1'b1;
        @(negedge clk); fb_below_hys = 1'b0;
        check("R8 skip set below band", int'(pulse_skip), 1);
        repeat (3) @(negedge clk);
        check("R8 skip held inside band", int'(pulse_skip), 1);
        fb_above_bm = 1'b1;
        @(negedge clk); fb_above_bm = 1'b0;
        check("R8 skip cleared above band", int'(pulse_skip), 0);
        repeat (3) @(negedge clk);
        check("R8 skip stays clear inside band", int'(pulse_skip), 0);

        // random mix, R3 R4 R5 R6 R2
        for (int i = 0; i < 150; i++) begin
            int mode;
            bit ocp;
            r = $urandom;
            mode = (r % 10 < 6) ? 1 : ((r % 10 < 8) ? 0 : 2 + int'((r >> 4) & 1));
            ocp  = ((r >> 8) % 3) == 0;
            run_cycle(mode, ocp, "R3/R5 random cycle");
            if (m_fault && ((r >> 16) & 1) == 1) do_uvlo();
        end

        finish_run();
    end
endmodule